// File: doc/BRIEF.md
# Interrupt Destination Matcher

This block answers one question for a single local interrupt controller: is it a target of an interrupt request that is currently on offer? It keeps three clocked registers (an identity word, a logical-identity word and a destination-format word) that are loaded through simple write strobes. A combinational path compares an incoming request with these registers. Each request carries an 8-bit destination, a physical/logical mode bit, a 2-bit shorthand and a flag that says the request comes from this controller itself.

The format register's top nibble selects the logical addressing mode. This nibble is the block's state variable and can take three decoded states. `FMT_FLAT` is entered on reset or by writing nibble 0xF. `FMT_CLUSTER` is entered by writing nibble 0x0. `FMT_BAD` is entered by writing any other nibble. Every write to the format register is a transition: it moves the block from its current state to the state that the written nibble decodes to. No other event changes the state.

The block produces a single `hit` bit and a `fmt_err` flag. A chip instantiates one matcher per controller and gathers the `hit` bits to form the delivery set.

Top module: `dest_matcher`

## Requirements
- R1: During and after reset, `id_q` holds `{RESET_ID, 24'h0}`, `lid_q` holds 0 and `fmt_q` holds 32'hFFFF_FFFF, which puts the block in `FMT_FLAT`.
- R2: When `id_wr_en` is high, `id_q` takes the whole of `id_wr_data` at the next rising edge. The physical identity is `id_q[31:24]`.
- R3: When `fmt_wr_en` is high, `fmt_q[31:28]` takes `fmt_wr_data[31:28]` at the next rising edge. `fmt_q[27:0]` always reads as all ones, whatever value is written.
- R4: With shorthand 0 and `req_logical`=0, `hit` is 1 exactly when `req_dest` is 0xFF or `req_dest` equals `id_q[31:24]`.
- R5: With shorthand 0 and `req_logical`=1 in `FMT_FLAT` (format nibble 0xF), `hit` is 1 exactly when `lid_q[31:24] & req_dest` is nonzero.
- R6: With shorthand 0 and `req_logical`=1 in `FMT_CLUSTER` (format nibble 0x0), `hit` is 1 exactly when the upper nibbles of `lid_q[31:24]` and `req_dest` are equal and the AND of their lower nibbles is nonzero.
- R7: With shorthand 0 and `req_logical`=1 in `FMT_BAD` (any other nibble), `hit` is 0 and `fmt_err` is 1.
- R8: Shorthand 1 (self only) gives `hit` equal to `req_from_self`. The destination, the mode bit and the format state are ignored.
- R9: Shorthand 2 (everyone including self) always gives `hit`=1.
- R10: Shorthand 3 (everyone but self) gives `hit` equal to the inverse of `req_from_self`.
- R11: `fmt_err` is 0 unless shorthand is 0, `req_logical` is 1 and the block is in `FMT_BAD`.
- R12: When `lid_wr_en` is high, `lid_q` takes the whole of `lid_wr_data` at the next rising edge. The logical identity is `lid_q[31:24]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_wr_en | input | 1 | Identity register write strobe |
| id_wr_data | input | 32 | Identity write word; bits 31:24 hold the physical identity |
| lid_wr_en | input | 1 | Logical-identity register write strobe |
| lid_wr_data | input | 32 | Logical-identity write word; bits 31:24 hold the logical identity |
| fmt_wr_en | input | 1 | Format register write strobe |
| fmt_wr_data | input | 32 | Format write word; only bits 31:28 are kept |
| req_dest | input | 8 | Request destination field |
| req_logical | input | 1 | 0 = physical, 1 = logical destination |
| req_shorthand | input | 2 | 0 field, 1 self, 2 all, 3 all but self |
| req_from_self | input | 1 | Request was issued by this controller |
| hit | output | 1 | This controller is a target |
| fmt_err | output | 1 | Logical request met an unusable format |
| id_q | output | 32 | Identity register contents |
| lid_q | output | 32 | Logical-identity register contents |
| fmt_q | output | 32 | Format register contents |

## Verification
On every cycle, the assertions check the following properties, which hold whatever the stored identities are:
- The three shorthand rules.
- The physical broadcast and equal-identity hits.
- The forced-ones format bits.
- The one-cycle loading of each register.
- The rule that `fmt_err` excludes `hit` and only occurs for logical requests without a shorthand.

The flat and cluster overlap rules depend on particular identity and destination values, so only the bench scenarios can show them. The bench sweeps every destination in each format state against a per-cycle reference model. The same applies to the miss cases of physical matching and to the transitions between format states.

// File: rtl/dm_pkg.sv
package dm_pkg;

    localparam int MODE_W = 4;

    localparam logic [MODE_W-1:0] FLAT_NIBBLE    = 4'hF;
    localparam logic [MODE_W-1:0] CLUSTER_NIBBLE = 4'h0;

    typedef enum logic [1:0] {
        SH_FIELD  = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } sh_e;

    typedef enum logic [1:0] {
        FMT_FLAT    = 2'd0,
        FMT_CLUSTER = 2'd1,
        FMT_BAD     = 2'd2
    } fmt_mode_e;

endpackage

// File: rtl/dm_regs.sv
module dm_regs
    import dm_pkg::*;
#(
    parameter int          REG_W    = 32,
    parameter int          ID_W     = 8,
    parameter logic [7:0]  RESET_ID = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_wr_en,
    input  logic [REG_W-1:0] id_wr_data,
    input  logic             lid_wr_en,
    input  logic [REG_W-1:0] lid_wr_data,
    input  logic             fmt_wr_en,
    input  logic [REG_W-1:0] fmt_wr_data,
    output logic [REG_W-1:0] id_word,
    output logic [REG_W-1:0] lid_word,
    output logic [REG_W-1:0] fmt_word
);

    localparam int FORCE_W = REG_W - MODE_W;
    localparam logic [REG_W-1:0] FORCE_MASK = {{MODE_W{1'b0}}, {FORCE_W{1'b1}}};
    localparam logic [REG_W-1:0] ID_RESET   = {RESET_ID, {(REG_W-8){1'b0}}};

    logic [REG_W-1:0] fmt_next;

    assign fmt_next = fmt_wr_data | FORCE_MASK;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_word <= ID_RESET;
        end else if (id_wr_en) begin
            id_word <= id_wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lid_word <= '0;
        end else if (lid_wr_en) begin
            lid_word <= lid_wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_word <= '1;
        end else if (fmt_wr_en) begin
            fmt_word <= fmt_next;
        end
    end

endmodule

// File: rtl/dm_fmt_decode.sv
module dm_fmt_decode
    import dm_pkg::*;
(
    input  logic [MODE_W-1:0] nibble,
    output fmt_mode_e         mode
);

    always_comb begin
        unique case (nibble)
            FLAT_NIBBLE:    mode = FMT_FLAT;
            CLUSTER_NIBBLE: mode = FMT_CLUSTER;
            default:        mode = FMT_BAD;
        endcase
    end

endmodule

// File: rtl/dm_logical_cmp.sv
module dm_logical_cmp #(
    parameter int ID_W = 8
) (
    input  logic [ID_W-1:0] lid,
    input  logic [ID_W-1:0] dest,
    output logic            flat_hit,
    output logic            cluster_hit
);

    localparam int HALF = ID_W / 2;

    logic [ID_W-1:0] overlap;

    for (genvar b = 0; b < ID_W; b++) begin : g_bit
        assign overlap[b] = lid[b] & dest[b];
    end

    logic group_eq;
    assign group_eq    = (lid[ID_W-1:HALF] == dest[ID_W-1:HALF]);
    assign flat_hit    = |overlap;
    assign cluster_hit = group_eq & (|overlap[HALF-1:0]);

endmodule

// File: rtl/dm_route.sv
module dm_route
    import dm_pkg::*;
(
    input  sh_e       shorthand,
    input  logic      logical,
    input  logic      from_self,
    input  fmt_mode_e mode,
    input  logic      phys_hit,
    input  logic      flat_hit,
    input  logic      cluster_hit,
    output logic      hit,
    output logic      fmt_err
);

    always_comb begin
        hit     = 1'b0;
        fmt_err = 1'b0;
        unique case (shorthand)
            SH_SELF:   hit = from_self;
            SH_ALL:    hit = 1'b1;
            SH_OTHERS: hit = ~from_self;
            SH_FIELD: begin
                if (!logical) begin
                    hit = phys_hit;
                end else begin
                    unique case (mode)
                        FMT_FLAT:    hit = flat_hit;
                        FMT_CLUSTER: hit = cluster_hit;
                        default:     fmt_err = 1'b1;
                    endcase
                end
            end
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/dest_matcher.sv
module dest_matcher
    import dm_pkg::*;
#(
    parameter int         REG_W    = 32,
    parameter int         ID_W     = 8,
    parameter logic [7:0] RESET_ID = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             id_wr_en,
    input  logic [REG_W-1:0] id_wr_data,
    input  logic             lid_wr_en,
    input  logic [REG_W-1:0] lid_wr_data,
    input  logic             fmt_wr_en,
    input  logic [REG_W-1:0] fmt_wr_data,
    input  logic [ID_W-1:0]  req_dest,
    input  logic             req_logical,
    input  logic [1:0]       req_shorthand,
    input  logic             req_from_self,
    output logic             hit,
    output logic             fmt_err,
    output logic [REG_W-1:0] id_q,
    output logic [REG_W-1:0] lid_q,
    output logic [REG_W-1:0] fmt_q
);

    localparam int FIELD_LSB = REG_W - ID_W;
    localparam int NIB_LSB   = REG_W - MODE_W;
    localparam logic [ID_W-1:0] BCAST = {ID_W{1'b1}};

    logic [ID_W-1:0] phys_id;
    logic [ID_W-1:0] log_id;
    fmt_mode_e       mode;
    logic            phys_hit;
    logic            flat_hit;
    logic            cluster_hit;

    dm_regs #(
        .REG_W    (REG_W),
        .ID_W     (ID_W),
        .RESET_ID (RESET_ID)
    ) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .id_wr_en    (id_wr_en),
        .id_wr_data  (id_wr_data),
        .lid_wr_en   (lid_wr_en),
        .lid_wr_data (lid_wr_data),
        .fmt_wr_en   (fmt_wr_en),
        .fmt_wr_data (fmt_wr_data),
        .id_word     (id_q),
        .lid_word    (lid_q),
        .fmt_word    (fmt_q)
    );

    assign phys_id = id_q[REG_W-1:FIELD_LSB];
    assign log_id  = lid_q[REG_W-1:FIELD_LSB];

    dm_fmt_decode decode_i (
        .nibble (fmt_q[REG_W-1:NIB_LSB]),
        .mode   (mode)
    );

    assign phys_hit = (req_dest == BCAST) || (req_dest == phys_id);

    dm_logical_cmp #(
        .ID_W (ID_W)
    ) cmp_i (
        .lid         (log_id),
        .dest        (req_dest),
        .flat_hit    (flat_hit),
        .cluster_hit (cluster_hit)
    );

    dm_route route_i (
        .shorthand   (sh_e'(req_shorthand)),
        .logical     (req_logical),
        .from_self   (req_from_self),
        .mode        (mode),
        .phys_hit    (phys_hit),
        .flat_hit    (flat_hit),
        .cluster_hit (cluster_hit),
        .hit         (hit),
        .fmt_err     (fmt_err)
    );

endmodule

// File: rtl/dest_matcher_chk.sv
module dest_matcher_chk #(
    parameter int REG_W = 32,
    parameter int ID_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             id_wr_en,
    input logic [REG_W-1:0] id_wr_data,
    input logic             lid_wr_en,
    input logic [REG_W-1:0] lid_wr_data,
    input logic             fmt_wr_en,
    input logic [REG_W-1:0] fmt_wr_data,
    input logic [ID_W-1:0]  req_dest,
    input logic             req_logical,
    input logic [1:0]       req_shorthand,
    input logic             req_from_self,
    input logic             hit,
    input logic             fmt_err,
    input logic [REG_W-1:0] id_q,
    input logic [REG_W-1:0] lid_q,
    input logic [REG_W-1:0] fmt_q
);

    localparam int FIELD_LSB = REG_W - ID_W;
    localparam int LOW_W     = REG_W - 4;

    // R2
    id_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        id_wr_en |=> (id_q == $past(id_wr_data)));

    // R12
    lid_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lid_wr_en |=> (lid_q == $past(lid_wr_data)));

    // R3
    fmt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_wr_en |=> (fmt_q[REG_W-1:LOW_W] == $past(fmt_wr_data[REG_W-1:LOW_W])));

    // R3
    fmt_low_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&fmt_q[LOW_W-1:0]));

    // R4
    phys_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_shorthand == 2'd0 && !req_logical && (&req_dest)) |-> hit);

    // R4
    phys_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_shorthand == 2'd0 && !req_logical && req_dest == id_q[REG_W-1:FIELD_LSB]) |-> hit);

    // R7
    err_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |-> !hit);

    // R8
    self_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_shorthand == 2'd1) |-> (hit == req_from_self));

    // R9
    all_incl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_shorthand == 2'd2) |-> hit);

    // R10
    all_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_shorthand == 2'd3) |-> (hit != req_from_self));

    // R11
    err_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |-> (req_shorthand == 2'd0 && req_logical));

endmodule

bind dest_matcher dest_matcher_chk #(
    .REG_W (REG_W),
    .ID_W  (ID_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .id_wr_en      (id_wr_en),
    .id_wr_data    (id_wr_data),
    .lid_wr_en     (lid_wr_en),
    .lid_wr_data   (lid_wr_data),
    .fmt_wr_en     (fmt_wr_en),
    .fmt_wr_data   (fmt_wr_data),
    .req_dest      (req_dest),
    .req_logical   (req_logical),
    .req_shorthand (req_shorthand),
    .req_from_self (req_from_self),
    .hit           (hit),
    .fmt_err       (fmt_err),
    .id_q          (id_q),
    .lid_q         (lid_q),
    .fmt_q         (fmt_q)
);

// File: tb/dest_matcher_tb_top.sv
`timescale 1ns/1ps
module dest_matcher_tb_top;

    localparam logic [7:0] RST_ID = 8'h05;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        id_wr_en = 1'b0;
    logic [31:0] id_wr_data = '0;
    logic        lid_wr_en = 1'b0;
    logic [31:0] lid_wr_data = '0;
    logic        fmt_wr_en = 1'b0;
    logic [31:0] fmt_wr_data = '0;
    logic [7:0]  req_dest = '0;
    logic        req_logical = 1'b0;
    logic [1:0]  req_shorthand = '0;
    logic        req_from_self = 1'b0;
    logic        hit;
    logic        fmt_err;
    logic [31:0] id_q;
    logic [31:0] lid_q;
    logic [31:0] fmt_q;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // reference model state
    int unsigned m_id;
    int unsigned m_lid;
    int unsigned m_fmt;

    always #2 clk = ~clk;

    dest_matcher #(.REG_W(32), .ID_W(8), .RESET_ID(RST_ID)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .id_wr_en(id_wr_en), .id_wr_data(id_wr_data),
        .lid_wr_en(lid_wr_en), .lid_wr_data(lid_wr_data),
        .fmt_wr_en(fmt_wr_en), .fmt_wr_data(fmt_wr_data),
        .req_dest(req_dest), .req_logical(req_logical),
        .req_shorthand(req_shorthand), .req_from_self(req_from_self),
        .hit(hit), .fmt_err(fmt_err),
        .id_q(id_q), .lid_q(lid_q), .fmt_q(fmt_q)
    );

    function automatic int unsigned top_byte(int unsigned w);
        return w / 32'h0100_0000;
    endfunction

    function automatic int unsigned mode_nib();
        return m_fmt / 32'h1000_0000;
    endfunction

    function automatic bit exp_err();
        return (req_shorthand == 0) && req_logical &&
               (mode_nib() != 15) && (mode_nib() != 0);
    endfunction

    function automatic bit exp_hit();
        int unsigned l, d;
        int common;
        l = top_byte(m_lid);
        d = req_dest;
        case (req_shorthand)
            1: return req_from_self;
            2: return 1'b1;
            3: return !req_from_self;
            default: begin
                if (!req_logical)
                    return (d == 255) || (d == top_byte(m_id));
                common = 0;
                if (mode_nib() == 15) begin
                    for (int k = 0; k < 8; k++)
                        if (((l >> k) & 1) == 1 && ((d >> k) & 1) == 1) common++;
                    return common > 0;
                end
                if (mode_nib() == 0) begin
                    if ((l / 16) != (d / 16)) return 1'b0;
                    for (int k = 0; k < 4; k++)
                        if (((l >> k) & 1) == 1 && ((d >> k) & 1) == 1) common++;
                    return common > 0;
                end
                return 1'b0;
            end
        endcase
    endfunction

    function automatic string hit_tag();
        if (!rst_n) return "R1";
        case (req_shorthand)
            1: return "R8";
            2: return "R9";
            3: return "R10";
            default: begin
                if (!req_logical) return "R4";
                if (mode_nib() == 15) return "R5";
                if (mode_nib() == 0) return "R6";
                return "R7";
            end
        endcase
    endfunction

    task automatic cmp(string tag, string what, int unsigned act, int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        if (!rst_n) begin
            m_id  = {RST_ID, 24'h0};
            m_lid = 0;
            m_fmt = 32'hFFFF_FFFF;
        end else begin
            if (id_wr_en)  m_id  = id_wr_data;
            if (lid_wr_en) m_lid = lid_wr_data;
            if (fmt_wr_en) m_fmt = fmt_wr_data | 32'h0FFF_FFFF;
        end
        @(negedge clk);
        if (!rst_n) begin
            cmp("R1", "id_q", id_q, m_id);
            cmp("R1", "lid_q", lid_q, m_lid);
            cmp("R1", "fmt_q", fmt_q, m_fmt);
        end else begin
            cmp("R2", "id_q", id_q, m_id);
            cmp("R12", "lid_q", lid_q, m_lid);
            cmp("R3", "fmt_q", fmt_q, m_fmt);
            cmp(hit_tag(), "hit", hit, exp_hit());
            cmp(exp_err() ? "R7" : "R11", "fmt_err", fmt_err, exp_err());
        end
        id_wr_en = 0; lid_wr_en = 0; fmt_wr_en = 0;
    endtask

    task automatic req(logic [7:0] d, logic lg, logic [1:0] sh, logic slf);
        req_dest = d; req_logical = lg; req_shorthand = sh; req_from_self = slf;
        tick();
    endtask

    task automatic sweep(logic lg);
        for (int d = 0; d < 256; d++) req(d[7:0], lg, 2'd0, 1'b0);
    endtask

    task automatic shorthands();
        for (int s = 1; s < 4; s++) begin
            req(8'h00, 1'b1, s[1:0], 1'b0);
            req(8'hFF, 1'b0, s[1:0], 1'b1);
        end
    endtask

    initial begin
        repeat (3) tick();                       // R1 during reset
        rst_n = 1'b1;
        tick();
        // R4 physical
        req(8'h05, 0, 0, 0); req(8'h06, 0, 0, 0);
        req(8'hFF, 0, 0, 0); req(8'h00, 0, 0, 0);
        // R2 identity write with junk low bits
        id_wr_en = 1; id_wr_data = 32'h3A12_3456; req(8'h05, 0, 0, 0);
        req(8'h3A, 0, 0, 0); req(8'h05, 0, 0, 0);
        // R12, R5 flat
        lid_wr_en = 1; lid_wr_data = 32'h25FF_FFFF; req(8'h01, 1, 0, 0);
        req(8'h02, 1, 0, 0); req(8'h20, 1, 0, 0); req(8'hDA, 1, 0, 0);
        sweep(1'b1);
        shorthands();
        // R3, R6 cluster
        fmt_wr_en = 1; fmt_wr_data = 32'h0000_0000; req(8'h21, 1, 0, 0);
        req(8'h24, 1, 0, 0); req(8'h22, 1, 0, 0); req(8'h31, 1, 0, 0); req(8'h2F, 1, 0, 0);
        sweep(1'b1);
        sweep(1'b0);
        shorthands();
        // R7, R11 bad format
        fmt_wr_en = 1; fmt_wr_data = 32'h8000_1234; req(8'h25, 1, 0, 0);
        sweep(1'b1);
        req(8'h3A, 0, 0, 0);
        shorthands();
        fmt_wr_en = 1; fmt_wr_data = 32'h7FFF_FFFF; req(8'hFF, 1, 0, 1);
        // back to flat
        fmt_wr_en = 1; fmt_wr_data = 32'hF000_0000; req(8'h04, 1, 0, 0);
        req(8'h80, 1, 0, 0);
        // write and request in the same cycle
        lid_wr_en = 1; lid_wr_data = 32'h8000_0000; req(8'h80, 1, 0, 0);
        req(8'h80, 1, 0, 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule